// File: doc/BRIEF.md
# Two-Stage Timer Clock Prescaler

This block derives a slow timer clock from a fast input clock. A linear stage divides the input by (M+1). An exponential stage then divides that rate by 2^(N+1). The result is a square wave with exactly 50% duty, together with a single-cycle tick that marks the start of each output period. With the smallest settings (M=0, N=0) the block divides by 2.

The setting is held in one 32-bit configuration register. M sits in bits [11:0] and N sits in bits [15:12]. Bits [31:16] are free storage: they read back as written and change nothing. A field-select input lets a write replace the whole word, only M, only N, or only the free upper half, so that software can update one field without a read-modify-write. A write lands in the register at once. The counters only take up the new ratio at the next output period boundary, which is the edge where the timer clock rises. A pending flag stays high in between, so no shortened or stretched pulse can appear.

A small phase state machine sequences the output. It has three states:
- PRIME: entered during reset, and left unconditionally for HIGH at the first clock after reset. That edge loads the register into the counters.
- HIGH: left for LOW when the exponential stage completes a half period.
- LOW: left for HIGH when the next half period completes. This transition is the period boundary: it reloads the counters from the register, raises the tick and clears the pending flag.

Top module: `tmr_prescaler`

## Requirements
- R1: While reset is high, the outputs are held low: tmr_clk, tmr_tick, cfg_pending and cfg_rdata are all 0.
- R1 (continued): At the first clock edge after reset, tmr_clk rises with a tick, using the reset setting M=0, N=0. This gives a divide-by-2 output.
- R2: The period of tmr_clk is 2^(N+1)·(M+1) input cycles, where M = register bits [11:0] and N = register bits [15:12].
- R3: Within each period, tmr_clk is high for exactly 2^N·(M+1) cycles and low for the same number of cycles.
- R4: tmr_tick is high for exactly one cycle per period, in the first cycle in which tmr_clk is high.
- R5: The ratio is exact at both ends of the field ranges. M=4095 with N=0 gives a period of 8192 cycles. M=0 with N=15 gives a period of 65536 cycles.
- R6: On a write, cfg_sel picks the bits that are replaced; all other bits keep their value.
  - 0 replaces all 32 bits.
  - 1 replaces only bits [11:0].
  - 2 replaces only bits [15:12].
  - 3 replaces only bits [31:16].
- R6 (continued): cfg_rdata shows the updated register from the cycle after the write.
- R7: Bits [31:16] read back as written and have no effect on the output ratio.
- R8: After a write, the output keeps its old timing until the next rise of tmr_clk. The new ratio applies from that rise onward.
- R9: cfg_pending goes high in the cycle after any write. It falls at the next rise of tmr_clk, in the same cycle as the tick.
- R10: A write captured on the very edge where tmr_clk rises is not used for the period that starts there. It takes effect one period later, and cfg_pending stays high through that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write field select (0 word, 1 M, 2 N, 3 upper) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Configuration register read-back |
| cfg_pending | output | 1 | A written setting is waiting for the next period boundary |
| tmr_clk | output | 1 | Divided 50%-duty timer clock |
| tmr_tick | output | 1 | One-cycle pulse at each rise of tmr_clk |

## Verification
The assertions check the following on every cycle:
- Tick and rising edge always coincide.
- The linear count never exceeds the active M, and the exponential count never passes its half-period limit.
- Successive linear steps are spaced by the active M.
- The active ratio changes only on a tick edge.
- The pending flag sets after every write and clears at an unblocked boundary.
- Field writes leave the unselected bits untouched.

Only the bench scenarios can show the rest:
- The measured period and duty match the formula for each setting.
- The extreme settings divide correctly.
- A write made mid-period, or exactly on a boundary edge, takes effect at the right rising edge.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int CFG_W  = 32;
    localparam int M_W    = 12;
    localparam int N_W    = 4;
    localparam int EXP_W  = 16;

    typedef enum logic [1:0] {
        WSEL_WORD  = 2'd0,
        WSEL_M     = 2'd1,
        WSEL_N     = 2'd2,
        WSEL_UPPER = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        PH_PRIME = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW   = 2'd2
    } phase_e;

endpackage

// File: rtl/presc_cfg_reg.sv
module presc_cfg_reg
    import presc_pkg::*;
#(
    parameter int DW = CFG_W,
    parameter int MW = M_W,
    parameter int NW = N_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_q,
    output logic [MW-1:0] m_field,
    output logic [NW-1:0] n_field
);

    localparam logic [DW-1:0] M_MASK  = DW'((64'd1 << MW) - 64'd1);
    localparam logic [DW-1:0] N_MASK  = DW'(((64'd1 << NW) - 64'd1) << MW);
    localparam logic [DW-1:0] UP_MASK = ~(M_MASK | N_MASK);

    wsel_e         sel_e;
    logic [DW-1:0] wr_mask;
    logic [DW-1:0] cfg_d;

    assign sel_e = wsel_e'(sel);

    always_comb begin
        unique case (sel_e)
            WSEL_WORD:  wr_mask = '1;
            WSEL_M:     wr_mask = M_MASK;
            WSEL_N:     wr_mask = N_MASK;
            WSEL_UPPER: wr_mask = UP_MASK;
            default:    wr_mask = '0;
        endcase
        cfg_d = (cfg_q & ~wr_mask) | (wdata & wr_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_d;
        end
    end

    assign m_field = cfg_q[MW-1:0];
    assign n_field = cfg_q[MW+NW-1:MW];

    // R6: a full-word write lands unchanged
    a_r6_word_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == WSEL_WORD) |=> cfg_q == $past(wdata));

    // R6: an M-only write keeps every bit above M
    a_r6_m_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == WSEL_M) |=> cfg_q[DW-1:MW] == $past(cfg_q[DW-1:MW]));

    // R6: an N-only write keeps M and the upper bits
    a_r6_n_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == WSEL_N) |=>
            (cfg_q[MW-1:0] == $past(cfg_q[MW-1:0])) &&
            (cfg_q[DW-1:MW+NW] == $past(cfg_q[DW-1:MW+NW])));

    // R7: an upper-only write never disturbs the ratio fields
    a_r7_upper_inert: assert property (@(posedge clk) disable iff (rst)
        (we && sel_e == WSEL_UPPER) |=> $stable(cfg_q[MW+NW-1:0]));

endmodule

// File: rtl/presc_lin_stage.sv
module presc_lin_stage #(
    parameter int MW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [MW-1:0] m_new,
    output logic          step_en,
    output logic [MW-1:0] cnt,
    output logic [MW-1:0] m_act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            m_act <= '0;
        end else if (load) begin
            cnt   <= m_new;
            m_act <= m_new;
        end else if (cnt == '0) begin
            cnt   <= m_act;
        end else begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign step_en = (cnt == '0);

    // R2: the linear count stays within the active M
    a_r2_lin_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= m_act);

    // R2: with M above zero, two steps never fall on adjacent cycles
    a_r2_step_gap: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load && m_act != '0) |=> !step_en);

endmodule

// File: rtl/presc_exp_stage.sv
module presc_exp_stage #(
    parameter int NW = 4,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NW-1:0] n_new,
    input  logic          step_en,
    output logic          half_done,
    output logic [EW-1:0] cnt,
    output logic [NW-1:0] n_act
);

    logic [EW-1:0] limit;

    always_comb begin
        limit = {EW{1'b1}} >> (EW - int'(n_act));
    end

    assign half_done = step_en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            n_act <= '0;
        end else if (load) begin
            cnt   <= '0;
            n_act <= n_new;
        end else if (step_en) begin
            if (cnt == limit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: the half-period count never passes 2^N-1
    a_r3_exp_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

endmodule

// File: rtl/presc_phase_fsm.sv
module presc_phase_fsm
    import presc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic half_done,
    output logic load,
    output logic clk_q,
    output logic tick_q,
    output logic pending_q
);

    phase_e state;
    phase_e nxt;

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            PH_PRIME: begin
                nxt  = PH_HIGH;
                load = 1'b1;
            end
            PH_HIGH: begin
                if (half_done) begin
                    nxt = PH_LOW;
                end
            end
            PH_LOW: begin
                if (half_done) begin
                    nxt  = PH_HIGH;
                    load = 1'b1;
                end
            end
            default: begin
                nxt = PH_PRIME;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_PRIME;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q     <= 1'b0;
            tick_q    <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            clk_q  <= (nxt == PH_HIGH);
            tick_q <= load;
            if (cfg_wr) begin
                pending_q <= 1'b1;
            end else if (load) begin
                pending_q <= 1'b0;
            end
        end
    end

    // R1: the priming state lasts a single cycle
    a_r1_prime_once: assert property (@(posedge clk) disable iff (rst)
        (state == PH_PRIME) |=> (state == PH_HIGH));

    // R9: a write always raises the pending flag
    a_r9_pend_set: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> pending_q);

    // R9: an unblocked boundary clears the pending flag
    a_r9_pend_clear: assert property (@(posedge clk) disable iff (rst)
        (pending_q && load && !cfg_wr) |=> !pending_q);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import presc_pkg::*;
#(
    parameter int DW = CFG_W,
    parameter int MW = M_W,
    parameter int NW = N_W,
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          cfg_pending,
    output logic          tmr_clk,
    output logic          tmr_tick
);

    logic [MW-1:0] m_field;
    logic [NW-1:0] n_field;
    logic          load;
    logic          step_en;
    logic          half_done;
    logic [MW-1:0] lin_cnt;
    logic [MW-1:0] m_act;
    logic [EW-1:0] exp_cnt;
    logic [NW-1:0] n_act;

    presc_cfg_reg #(.DW(DW), .MW(MW), .NW(NW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_rdata),
        .m_field (m_field),
        .n_field (n_field)
    );

    presc_lin_stage #(.MW(MW)) u_lin (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .m_new   (m_field),
        .step_en (step_en),
        .cnt     (lin_cnt),
        .m_act   (m_act)
    );

    presc_exp_stage #(.NW(NW), .EW(EW)) u_exp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .n_new     (n_field),
        .step_en   (step_en),
        .half_done (half_done),
        .cnt       (exp_cnt),
        .n_act     (n_act)
    );

    presc_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_we),
        .half_done (half_done),
        .load      (load),
        .clk_q     (tmr_clk),
        .tick_q    (tmr_tick),
        .pending_q (cfg_pending)
    );

    // R4: a tick only ever appears on a rising edge of tmr_clk
    a_r4_tick_on_rise: assert property (@(posedge clk) disable iff (rst)
        tmr_tick |-> (tmr_clk && !$past(tmr_clk)));

    // R4: every rising edge of tmr_clk carries a tick
    a_r4_rise_has_tick: assert property (@(posedge clk) disable iff (rst)
        (tmr_clk && !$past(tmr_clk)) |-> tmr_tick);

    // R8: the active ratio only moves at a period boundary
    a_r8_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        !tmr_tick |-> ($stable(m_act) && $stable(n_act)));

    // R2: the two stage counters are never both idle past their limits
    a_r2_counts_sane: assert property (@(posedge clk) disable iff (rst)
        (lin_cnt <= m_act) && (exp_cnt < (EW'(1) << n_act)));

endmodule

// File: tb/test_tmr_prescaler.sv
`timescale 1ns/1ps
module test_tmr_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        cfg_pending;
    logic        tmr_clk;
    logic        tmr_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t sbq[$];

    always #4 clk = ~clk;

    tmr_prescaler i_tmr_prescaler (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .cfg_pending (cfg_pending),
        .tmr_clk     (tmr_clk),
        .tmr_tick    (tmr_tick)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measures each period from rise to rise and compares it
    // with the next queued expectation.
    initial begin
        bit prev = 1'b0;
        bit started = 1'b0;
        int hi = 0;
        int lo = 0;
        int tk = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = 1'b0;
                started = 1'b0;
            end else begin
                if (tmr_clk && !prev) begin
                    if (started && sbq.size() > 0) begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(hi + lo == e.hi + e.lo, {"R2 period ", e.tag}, hi + lo, e.hi + e.lo);
                        chk(hi == e.hi && lo == e.lo, {"R3 high time ", e.tag}, hi, e.hi);
                        chk(tk == 1, {"R4 ticks per period ", e.tag}, tk, 1);
                    end
                    started = 1'b1;
                    hi = 0;
                    lo = 0;
                    tk = 0;
                end
                if (started) begin
                    if (tmr_clk) hi++; else lo++;
                    if (tmr_tick) tk++;
                end
                prev = tmr_clk;
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tmr_tick);
    endtask

    task automatic expect_periods(input int m, input int n, input int k, input string tag);
        for (int i = 0; i < k; i++) begin
            exp_t e;
            e.hi  = (1 << n) * (m + 1);
            e.lo  = e.hi;
            e.tag = tag;
            sbq.push_back(e);
        end
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // Driver: writes a full word, waits for the boundary, queues expectations
    task automatic apply(input int m, input int n, input int k, input string tag);
        cfg_wr(2'd0, {16'h0, 4'(n), 12'(m)});
        chk(cfg_pending == 1'b1, "R9 pending after write", cfg_pending, 1);
        while (cfg_pending) @(negedge clk);
        chk(tmr_tick == 1'b1, "R9 pending drops with tick", tmr_tick, 1);
        @(negedge clk);
        expect_periods(m, n, k, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset values
        repeat (3) @(negedge clk);
        chk(tmr_clk == 1'b0, "R1 clk in reset", tmr_clk, 0);
        chk(tmr_tick == 1'b0, "R1 tick in reset", tmr_tick, 0);
        chk(cfg_pending == 1'b0, "R1 pending in reset", cfg_pending, 0);
        chk(cfg_rdata == 32'd0, "R1 rdata in reset", cfg_rdata, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tmr_clk == 1'b1 && tmr_tick == 1'b1, "R1 first rise after reset", {tmr_clk, tmr_tick}, 3);
        @(negedge clk);
        chk(tmr_clk == 1'b0 && tmr_tick == 1'b0, "R1 divide by 2 low half", {tmr_clk, tmr_tick}, 0);
        @(negedge clk);
        chk(tmr_clk == 1'b1 && tmr_tick == 1'b1, "R4 tick on second rise", {tmr_clk, tmr_tick}, 3);
        expect_periods(0, 0, 3, "m0n0");

        // R2 R3: several ratios
        apply(3, 1, 2, "m3n1");
        apply(5, 2, 2, "m5n2");
        apply(6, 0, 2, "m6n0");

        // R6 R7: field-select writes
        apply(3, 1, 1, "m3n1b");
        cfg_wr(2'd1, 32'hFFFF_F005);
        chk(cfg_rdata == 32'h0000_1005, "R6 M-only write", cfg_rdata, 32'h0000_1005);
        cfg_wr(2'd2, 32'hABCD_2FFF);
        chk(cfg_rdata == 32'h0000_2005, "R6 N-only write", cfg_rdata, 32'h0000_2005);
        cfg_wr(2'd3, 32'h5A5A_FFFF);
        chk(cfg_rdata == 32'h5A5A_2005, "R7 upper readback", cfg_rdata, 32'h5A5A_2005);
        while (cfg_pending) @(negedge clk);
        @(negedge clk);
        expect_periods(5, 2, 2, "R7 upper bits inert m5n2");

        // R8: mid-period write keeps old timing until next rise
        apply(1, 1, 1, "m1n1");
        wait_tick();
        cfg_wr(2'd0, 32'h0000_0002);
        chk(cfg_pending == 1'b1, "R9 pending set mid-period", cfg_pending, 1);
        n = 1;
        while (!tmr_tick) begin @(negedge clk); n++; end
        chk(n == 8, "R8 old period kept", n, 8);
        chk(cfg_pending == 1'b0, "R9 pending cleared at rise", cfg_pending, 0);
        @(negedge clk);
        expect_periods(2, 0, 2, "R8 new ratio m2n0");

        // R10: write captured on the boundary edge waits one more period
        apply(3, 1, 1, "m3n1c");
        wait_tick();
        repeat (15) @(negedge clk);
        cfg_wr(2'd0, 32'h0000_1001);
        chk(tmr_tick == 1'b1, "R10 write on boundary edge", tmr_tick, 1);
        chk(cfg_pending == 1'b1, "R10 pending survives boundary", cfg_pending, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (!tmr_tick);
        chk(n == 16, "R10 old ratio one more period", n, 16);
        chk(cfg_pending == 1'b0, "R10 pending cleared next boundary", cfg_pending, 0);
        @(negedge clk);
        expect_periods(1, 1, 2, "R10 m1n1");

        // R5: extremes
        apply(4095, 0, 1, "R5 m4095n0");
        apply(0, 15, 1, "R5 m0n15");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule